// File: doc/BRIEF.md
# BCD Calendar Date Counter

This block keeps a calendar date as eight packed BCD digits, ordered day, month, then a four-digit year. Each advance pulse moves the date on by one calendar day. The day rolls over into the month, and the month rolls over into the year. The last day of each month comes from the month number and from a leap-year test, which the block computes directly on the BCD year digits. A leap-year flag is driven out so that it can light an indicator.

For manual setting, an edit request names one digit by index and bumps that digit by one. Each digit wraps inside its own legal range. If the bump would leave an illegal date, the affected field is pulled back to the nearest legal value in the same clock. The stored date is therefore always a real calendar date. Display decoding, button debouncing and mode selection sit outside the block.

Top module: `bcdDateCounter`

## Requirements
- R1: An active-low asynchronous reset loads 01/01/2000. The output `dateBcd` packs one BCD digit per nibble, from the top nibble down: day tens, day ones, month tens, month ones, year thousands, year hundreds, year tens, year ones. The reset value is therefore 32'h0101_2000.
- R2: An advance pulse on a day below the month's last day adds one to the day in BCD (09 becomes 10). Month and year stay unchanged.
- R3: The last day is 30 for months 04, 06, 09 and 11. It is 28 or 29 for month 02, and 31 for every other month. Advancing on the last day gives day 01 and the next month.
- R4: Advancing on 31/12 gives 01/01 and adds one to the year with BCD carry. Year 9999 wraps to 0000.
- R5: `leapYear` is high exactly when the current year is a multiple of 4 and not a multiple of 100, or is a multiple of 400. Year 0000 counts as a leap year.
- R6: With neither advance nor edit requested, the date holds.
- R7: An edit request adds one to the digit chosen by `editIdx`. The index numbers the digits 0 to 7 in the same order as R1, so 0 is day tens and 7 is year ones. Day tens wraps from 3 to 0, month tens wraps from 1 to 0, and every other digit wraps from 9 to 0. No other digit changes unless R8 applies.
- R8: After an edit, a month of 00 becomes 01 and a month above 12 becomes 12. Then a day of 00 becomes 01, and a day above the last day of the (possibly new) month and year becomes that last day. All of this happens in the same clock.
- R9: When advance and edit are requested in the same cycle, only the advance takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | One-cycle request to step forward one day |
| editReq | input | 1 | One-cycle request to bump the digit chosen by `editIdx` |
| editIdx | input | 3 | Digit index for an edit, 0 = day tens to 7 = year ones |
| dateBcd | output | 32 | Current date as eight BCD digits, DD MM YYYY |
| leapYear | output | 1 | High when the current year is a leap year |

## Verification
A wrong digit register or a bad BCD carry shows on `dateBcd` at the clock edge right after the advance or edit that caused it. A wrong month limit or leap decision shows no earlier than the step past the last day of an affected month. That step lands on the wrong day, or leaves the month unchanged. Because of this, the bench sweeps all ten thousand years for the leap flag and compares a run of more than four years of daily steps against an arithmetic calendar model. Clamping faults appear only in the clock of the edit that triggers them, so each clamp rule is driven directly and checked at that edge.

// File: rtl/datePkg.sv
package datePkg;
  localparam int DIGIT_W     = 4;
  localparam int NUM_DIGITS  = 8;
  localparam int YEAR_DIGITS = 4;
  localparam int IDX_W       = $clog2(NUM_DIGITS);
  localparam int LIMIT_W     = 5;
  localparam int DATE_W      = NUM_DIGITS * DIGIT_W;

  // digit positions inside the stored date; neighbours decode these
  localparam int DAY_T  = 0;
  localparam int DAY_O  = 1;
  localparam int MON_T  = 2;
  localparam int MON_O  = 3;
  localparam int YR_TH  = 4;
  localparam int YR_HU  = 5;
  localparam int YR_TE  = 6;
  localparam int YR_ON  = 7;

  typedef logic [DIGIT_W-1:0] bcd_t;

  typedef struct packed {
    logic             dayInc;
    logic             dayWrap;
    logic             monInc;
    logic             monWrap;
    logic             yearInc;
    logic             editEn;
    logic [IDX_W-1:0] editSel;
  } dateCtrl_t;

  function automatic logic [6:0] pairToBin(bcd_t tens, bcd_t ones);
    return 7'(tens) * 7'd10 + 7'(ones);
  endfunction

  // two-digit BCD number divisible by four
  function automatic logic pairDiv4(bcd_t tens, bcd_t ones);
    if (tens[0]) return (ones == 4'd2) || (ones == 4'd6);
    return (ones == 4'd0) || (ones == 4'd4) || (ones == 4'd8);
  endfunction

  function automatic bcd_t digitTop(int idx);
    case (idx)
      DAY_T:   return 4'd3;
      MON_T:   return 4'd1;
      default: return 4'd9;
    endcase
  endfunction

  function automatic logic [7:0] limitToBcd(logic [LIMIT_W-1:0] lim);
    if (lim >= 5'd30) return {4'd3, 4'(lim - 5'd30)};
    return {4'd2, 4'(lim - 5'd20)};
  endfunction
endpackage

// File: rtl/leapTest.sv
module leapTest
  import datePkg::*;
(
  input  bcd_t yrThou,
  input  bcd_t yrHund,
  input  bcd_t yrTens,
  input  bcd_t yrOnes,
  output logic isLeap
);
  logic lowZero;

  always_comb begin
    lowZero = (yrTens == 4'd0) && (yrOnes == 4'd0);
    // a century year falls back to the test on its upper pair
    isLeap  = lowZero ? pairDiv4(yrThou, yrHund) : pairDiv4(yrTens, yrOnes);
  end
endmodule

// File: rtl/monthLimit.sv
module monthLimit
  import datePkg::*;
(
  input  bcd_t               monTens,
  input  bcd_t               monOnes,
  input  logic               leap,
  output logic [LIMIT_W-1:0] lastDay
);
  logic [6:0] monBin;

  always_comb begin
    monBin = pairToBin(monTens, monOnes);
    case (monBin)
      7'd2:                     lastDay = leap ? 5'd29 : 5'd28;
      7'd4, 7'd6, 7'd9, 7'd11:  lastDay = 5'd30;
      default:                  lastDay = 5'd31;
    endcase
  end
endmodule

// File: rtl/dateControl.sv
module dateControl
  import datePkg::*;
(
  input  logic             advance,
  input  logic             editReq,
  input  logic [IDX_W-1:0] editIdx,
  input  logic             atMonthEnd,
  input  logic             atYearEnd,
  output dateCtrl_t        ctrl
);
  always_comb begin
    ctrl         = '0;
    ctrl.dayInc  = advance && !atMonthEnd;
    ctrl.dayWrap = advance && atMonthEnd;
    ctrl.monInc  = advance && atMonthEnd && !atYearEnd;
    ctrl.monWrap = advance && atMonthEnd && atYearEnd;
    ctrl.yearInc = advance && atMonthEnd && atYearEnd;
    // stepping wins over a manual bump in the same cycle
    ctrl.editEn  = editReq && !advance;
    ctrl.editSel = editIdx;
  end
endmodule

// File: rtl/dateDatapath.sv
module dateDatapath
  import datePkg::*;
#(
  parameter logic [DATE_W-1:0] RESET_DATE = 32'h0101_2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dateCtrl_t         ctrl,
  output logic [DATE_W-1:0] dateBcd,
  output logic              leapYear,
  output logic              atMonthEnd,
  output logic              atYearEnd
);
  bcd_t dig     [NUM_DIGITS];
  bcd_t digNext [NUM_DIGITS];
  bcd_t advNext [NUM_DIGITS];
  bcd_t edRaw   [NUM_DIGITS];
  bcd_t edFix   [NUM_DIGITS];
  bcd_t edDone  [NUM_DIGITS];
  bcd_t wrapInc [NUM_DIGITS];
  bcd_t yrIncd  [YEAR_DIGITS];
  logic [YEAR_DIGITS-1:0] yCarry;

  logic               curLeap;
  logic               edLeap;
  logic [LIMIT_W-1:0] curLimit;
  logic [LIMIT_W-1:0] edLimit;
  logic [6:0]         edMonBin;
  logic [6:0]         edDayBin;
  logic [7:0]         edLimBcd;

  // state
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_DIGITS; i++)
        dig[i] <= RESET_DATE[(NUM_DIGITS-1-i)*DIGIT_W +: DIGIT_W];
    end else begin
      dig <= digNext;
    end
  end

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_pack
    assign dateBcd[(NUM_DIGITS-1-i)*DIGIT_W +: DIGIT_W] = dig[i];
  end

  // current-date limit and flags
  leapTest u_curLeap (
    .yrThou(dig[YR_TH]), .yrHund(dig[YR_HU]),
    .yrTens(dig[YR_TE]), .yrOnes(dig[YR_ON]),
    .isLeap(curLeap)
  );

  monthLimit u_curLimit (
    .monTens(dig[MON_T]), .monOnes(dig[MON_O]),
    .leap(curLeap), .lastDay(curLimit)
  );

  assign leapYear   = curLeap;
  assign atMonthEnd = pairToBin(dig[DAY_T], dig[DAY_O]) >= {2'b00, curLimit};
  assign atYearEnd  = pairToBin(dig[MON_T], dig[MON_O]) >= 7'd12;

  // year ripple increment, ones digit first
  assign yCarry[0] = 1'b1;
  for (genvar k = 0; k < YEAR_DIGITS; k++) begin : g_year
    localparam int P = NUM_DIGITS - 1 - k;
    assign yrIncd[k] = (yCarry[k] && dig[P] == 4'd9) ? 4'd0
                                                     : dig[P] + {3'b000, yCarry[k]};
    if (k < YEAR_DIGITS - 1) begin : g_carry
      assign yCarry[k+1] = yCarry[k] && (dig[P] == 4'd9);
    end
  end

  // per-digit wrapped increment for editing
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_wrap
    assign wrapInc[i] = (dig[i] >= digitTop(i)) ? 4'd0 : dig[i] + 4'd1;
  end

  // calendar step
  always_comb begin
    advNext = dig;
    if (ctrl.dayWrap) begin
      advNext[DAY_T] = 4'd0;
      advNext[DAY_O] = 4'd1;
    end else if (ctrl.dayInc) begin
      if (dig[DAY_O] == 4'd9) begin
        advNext[DAY_T] = dig[DAY_T] + 4'd1;
        advNext[DAY_O] = 4'd0;
      end else begin
        advNext[DAY_O] = dig[DAY_O] + 4'd1;
      end
    end
    if (ctrl.monWrap) begin
      advNext[MON_T] = 4'd0;
      advNext[MON_O] = 4'd1;
    end else if (ctrl.monInc) begin
      if (dig[MON_O] == 4'd9) begin
        advNext[MON_T] = dig[MON_T] + 4'd1;
        advNext[MON_O] = 4'd0;
      end else begin
        advNext[MON_O] = dig[MON_O] + 4'd1;
      end
    end
    if (ctrl.yearInc) begin
      for (int k = 0; k < YEAR_DIGITS; k++)
        advNext[NUM_DIGITS-1-k] = yrIncd[k];
    end
  end

  // edit: bump one digit, then repair month
  always_comb begin
    edRaw = dig;
    edRaw[ctrl.editSel] = wrapInc[ctrl.editSel];
    edFix = edRaw;
    edMonBin = pairToBin(edRaw[MON_T], edRaw[MON_O]);
    if (edMonBin == 7'd0) begin
      edFix[MON_T] = 4'd0;
      edFix[MON_O] = 4'd1;
    end else if (edMonBin > 7'd12) begin
      edFix[MON_T] = 4'd1;
      edFix[MON_O] = 4'd2;
    end
  end

  leapTest u_edLeap (
    .yrThou(edFix[YR_TH]), .yrHund(edFix[YR_HU]),
    .yrTens(edFix[YR_TE]), .yrOnes(edFix[YR_ON]),
    .isLeap(edLeap)
  );

  monthLimit u_edLimit (
    .monTens(edFix[MON_T]), .monOnes(edFix[MON_O]),
    .leap(edLeap), .lastDay(edLimit)
  );

  // edit: repair day against the repaired month and year
  always_comb begin
    edDone   = edFix;
    edDayBin = pairToBin(edFix[DAY_T], edFix[DAY_O]);
    edLimBcd = limitToBcd(edLimit);
    if (edDayBin == 7'd0) begin
      edDone[DAY_T] = 4'd0;
      edDone[DAY_O] = 4'd1;
    end else if (edDayBin > {2'b00, edLimit}) begin
      edDone[DAY_T] = edLimBcd[7:4];
      edDone[DAY_O] = edLimBcd[3:0];
    end
  end

  always_comb begin
    if (ctrl.editEn) digNext = edDone;
    else             digNext = advNext;
  end
endmodule

// File: rtl/bcdDateCounter.sv
module bcdDateCounter
  import datePkg::*;
#(
  parameter logic [DATE_W-1:0] RESET_DATE = 32'h0101_2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              editReq,
  input  logic [IDX_W-1:0]  editIdx,
  output logic [DATE_W-1:0] dateBcd,
  output logic              leapYear
);
  dateCtrl_t ctrl;
  logic      atMonthEnd;
  logic      atYearEnd;

  dateControl u_ctrl (
    .advance(advance), .editReq(editReq), .editIdx(editIdx),
    .atMonthEnd(atMonthEnd), .atYearEnd(atYearEnd), .ctrl(ctrl)
  );

  dateDatapath #(.RESET_DATE(RESET_DATE)) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .dateBcd(dateBcd), .leapYear(leapYear),
    .atMonthEnd(atMonthEnd), .atYearEnd(atYearEnd)
  );
endmodule

// File: rtl/bcdDateCounterChk.sv
module bcdDateCounterChk
  import datePkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              advance,
  input logic              editReq,
  input logic [IDX_W-1:0]  editIdx,
  input logic [DATE_W-1:0] dateBcd,
  input logic              leapYear
);
  // R8: stored date always a legal BCD date
  a_r8_date_legal: assert property (@(posedge clk) disable iff (!rstN)
    (dateBcd[31:28] <= 4'd3) && (dateBcd[27:24] <= 4'd9) &&
    (dateBcd[31:24] != 8'h00) && (dateBcd[31:24] <= 8'h31) &&
    (dateBcd[23:16] != 8'h00) && (dateBcd[23:16] <= 8'h12) &&
    (dateBcd[19:16] <= 4'd9) && (dateBcd[15:12] <= 4'd9) &&
    (dateBcd[11:8] <= 4'd9) && (dateBcd[7:4] <= 4'd9) && (dateBcd[3:0] <= 4'd9));

  // R6: idle cycles leave the date alone
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !editReq) |=> $stable(dateBcd));

  // R2: a mid-month step bumps only the day ones digit
  a_r2_day_step: assert property (@(posedge clk) disable iff (!rstN)
    (advance && dateBcd[31:28] < 4'd2 && dateBcd[27:24] < 4'd8) |=>
      (dateBcd[27:24] == $past(dateBcd[27:24]) + 4'd1) &&
      $stable(dateBcd[31:28]) && $stable(dateBcd[23:0]));

  // R4: last day of year 9999 wraps to the first day of 0000
  a_r4_year_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (advance && dateBcd == 32'h3112_9999) |=> (dateBcd == 32'h0101_0000));

  // R5: the flag depends on the year only
  a_r5_leap_follows_year: assert property (@(posedge clk) disable iff (!rstN)
    $stable(dateBcd[15:0]) |-> $stable(leapYear));

  // R7: a day-digit edit never touches month or year
  a_r7_day_edit_local: assert property (@(posedge clk) disable iff (!rstN)
    (editReq && !advance && editIdx <= 3'd1) |=> $stable(dateBcd[23:0]));
endmodule

bind bcdDateCounter bcdDateCounterChk u_chk (.*);

// File: tb/bcdDateCounter_bench.sv
module bcdDateCounter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        advance;
  logic        editReq;
  logic [2:0]  editIdx;
  logic [31:0] dateBcd;
  logic        leapYear;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcdDateCounter u_bcdDateCounter (
    .clk(clk), .rstN(rstN), .advance(advance), .editReq(editReq),
    .editIdx(editIdx), .dateBcd(dateBcd), .leapYear(leapYear)
  );

  function automatic int isLeap(int y);
    return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0) ? 1 : 0;
  endfunction

  function automatic int daysIn(int m, int y);
    if (m == 2) return isLeap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [31:0] packDate(int d, int m, int y);
    return {4'(d / 10), 4'(d % 10), 4'(m / 10), 4'(m % 10),
            4'(y / 1000), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
  endfunction

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic edit(int idx);
    @(negedge clk);
    editReq = 1'b1;
    editIdx = 3'(idx);
    @(negedge clk);
    editReq = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
    advance = 1'b1;
    @(negedge clk);
    advance = 1'b0;
  endtask

  function automatic int digitOf(int idx);
    return int'(dateBcd[(7 - idx) * 4 +: 4]);
  endfunction

  task automatic setDigit(int idx, int target);
    for (int n = 0; n < 10; n++) begin
      if (digitOf(idx) == target) break;
      edit(idx);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, m, y;
    string tag;
    logic [31:0] held;
    rstN = 1'b0; advance = 1'b0; editReq = 1'b0; editIdx = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset value, R5 flag for 2000
    checkVal("R1 reset date", dateBcd, 32'h0101_2000);
    checkVal("R5 reset leap", {31'd0, leapYear}, 32'd1);

    // R6 idle hold
    held = dateBcd;
    repeat (5) begin
      @(negedge clk);
      checkVal("R6 idle hold", dateBcd, held);
    end

    // R5/R7 sweep every year via single-digit edits at 01/01
    y = 2000;
    for (int n = 0; n < 10000; n++) begin
      edit(7);
      if (y % 10 == 9)     edit(6);
      if (y % 100 == 99)   edit(5);
      if (y % 1000 == 999) edit(4);
      y = (y + 1) % 10000;
      checkVal("R7 year edit", dateBcd, packDate(1, 1, y));
      checkVal("R5 leap flag", {31'd0, leapYear}, 32'(isLeap(y)));
    end

    // R2/R3/R4 daily steps against the arithmetic calendar
    d = 1; m = 1; y = 2000;
    for (int n = 0; n < 1600; n++) begin
      step();
      tag = "R2 day step";
      d++;
      if (d > daysIn(m, y)) begin
        d = 1; m++; tag = "R3 month roll";
        if (m > 12) begin
          m = 1; y = (y + 1) % 10000; tag = "R4 year roll";
        end
      end
      checkVal(tag, dateBcd, packDate(d, m, y));
      checkVal("R5 leap during run", {31'd0, leapYear}, 32'(isLeap(y)));
    end

    // R4 wrap of 9999
    doReset();
    setDigit(4, 9); setDigit(5, 9); setDigit(6, 9); setDigit(7, 9);
    setDigit(2, 1); setDigit(3, 2); setDigit(0, 3);
    checkVal("R7 set 31/12/9999", dateBcd, 32'h3112_9999);
    checkVal("R5 leap 9999", {31'd0, leapYear}, 32'd0);
    step();
    checkVal("R4 wrap to 0000", dateBcd, 32'h0101_0000);
    checkVal("R5 leap 0000", {31'd0, leapYear}, 32'd1);

    // R3 February of a century common year
    doReset();
    setDigit(5, 1); setDigit(3, 2); setDigit(0, 2); setDigit(1, 8);
    checkVal("R7 set 28/02/2100", dateBcd, 32'h2802_2100);
    step();
    checkVal("R3 end of Feb 2100", dateBcd, 32'h0103_2100);

    // R8 day ones wrap to 00 is repaired
    doReset();
    setDigit(1, 9);
    edit(1);
    checkVal("R8 day 00 to 01", dateBcd, 32'h0101_2000);

    // R8 month 00 repaired
    doReset();
    setDigit(3, 9);
    edit(3);
    checkVal("R8 month 00 to 01", dateBcd, 32'h0101_2000);

    // R8 month above 12, R7 month tens wrap
    doReset();
    setDigit(3, 9);
    edit(2);
    checkVal("R8 month 19 to 12", dateBcd, 32'h0112_2000);
    edit(3);
    checkVal("R8 month 13 to 12", dateBcd, 32'h0112_2000);
    edit(2);
    checkVal("R7 month tens wrap", dateBcd, 32'h0102_2000);

    // R8 day repaired against new month and new year
    doReset();
    setDigit(0, 3);
    edit(3);
    checkVal("R8 day 31 in Feb 2000", dateBcd, 32'h2902_2000);
    edit(7);
    checkVal("R8 day 29 in Feb 2001", dateBcd, 32'h2802_2001);
    edit(0);
    checkVal("R8 day 38 to 28", dateBcd, 32'h2802_2001);

    // R7 day tens wrap 3 to 0
    doReset();
    setDigit(0, 3);
    edit(0);
    checkVal("R7 day tens wrap", dateBcd, 32'h0101_2000);

    // R9 advance wins over edit
    doReset();
    @(negedge clk);
    advance = 1'b1; editReq = 1'b1; editIdx = 3'd0;
    @(negedge clk);
    advance = 1'b0; editReq = 1'b0;
    checkVal("R9 advance priority", dateBcd, 32'h0201_2000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule